// File: doc/BRIEF.md
# PCI Configuration Header Responder

This block answers configuration reads and writes for a simple PCI type-0 endpoint. A requester presents one access per cycle: a request strobe, a write flag, a byte offset into the 256-byte configuration space, an access size (byte, halfword or word) and right-justified write data. Reads return one cycle later on a registered data port with a valid strobe. Writes return nothing.

The block holds the command register and a bank of six base address registers. The first is an I/O window of one byte and the second is a 256-byte 32-bit memory window. The other four are not implemented. The block supports the usual sizing handshake: software writes all ones to a BAR, and the read that follows returns a mask that encodes the window size and type. Identity words are fixed by parameters. A read-only capability chain links power management, PCI Express and MSI-X. A strap input can append an Enhanced Allocation header to the end of that chain.

The block exports the current BAR contents, with the space bit cleared, so that neighbouring address decoders can match transactions against them.

Top module: `cfg_hdr_responder`

## Requirements
- R1: The 16-bit command register sits in the low half of the word at offset 0x04. It returns the last value written to it. The upper half of that word reads as zero and ignores writes.
- R2: The word at 0x00 reads {DEVICE_ID, VENDOR_ID}. The word at 0x08 reads {CLASS_CODE, REV_ID}. The header-type byte at 0x0E reads zero. Any offset not named in these requirements reads zero.
- R3: The BARs at 0x18, 0x1C, 0x20 and 0x24 ignore writes and always read zero. Their slots on the exported base bus stay zero.
- R4: A write to BAR0 (0x10, I/O) stores the merged value ORed with 1 in bit 0. A write to BAR1 (0x14, memory) stores the merged value with bit 0 exactly as written.
- R5: A word read of an implemented BAR that holds all ones returns a sizing mask instead of the stored value. For BAR0 the mask is 0xFFFFFFFD. For BAR1 it is 0xFFFFFF00.
- R6: The byte at 0x34 reads 0x40. Capability headers carry the ID in bits 7:0 and the next pointer in bits 15:8. They chain 0x40 (ID 0x01) to 0x50 (ID 0x10) to 0x70 (ID 0x11).
- R7: When ea_strap is 0, the next pointer at 0x70 is zero and 0x80 reads zero. When ea_strap is 1, the next pointer at 0x70 is 0x80, and 0x80 reads 0x00040014: entry count 4 in bits 23:16, next pointer 0, ID 0x14.
- R8: cfg_size encodes 0 as byte, 1 as halfword and 2 or 3 as word. A byte read returns bits [8*k+7 : 8*k] of the aligned word, where k is offset[1:0], zero-extended. A halfword read returns 16 bits taken from the same shift.
- R9: A byte write changes only lane offset[1:0]. A halfword write changes only lanes 2*offset[1] and 2*offset[1]+1. A word write changes all four lanes.
- R10: rd_valid is high in the cycle after a read request and only then. A write request never raises rd_valid.
- R11: After reset, the command register and all BARs read zero, and bar_base is zero.
- R12: bar_base[32*i+31 : 32*i] equals BAR i with bit 0 cleared. It takes on its new value in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_req | input | 1 | Access request strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_off | input | 8 | Byte offset into configuration space |
| cfg_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| cfg_wdata | input | 32 | Right-justified write data |
| ea_strap | input | 1 | Appends the Enhanced Allocation header to the chain |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data, zero-extended for sub-word reads |
| bar_base | output | 192 | Six BAR bases, BAR0 in bits 31:0, with bit 0 cleared |

## Verification
BAR writes are exercised with an ordinary base value, a byte-lane patch and the all-ones sizing pattern. Comparing these separates a stored value from a sizing mask and from a write that spills into the wrong lane. The same all-ones and arbitrary patterns are sent to the unimplemented BARs and to the upper half of the command word, which shows that they are discarded. The capability chain is walked with the strap at both values, and the reads mix byte, halfword and word sizes at non-zero lanes. A lane-extraction or link error therefore shows up as a wrong byte rather than hiding behind an aligned word.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  // Lanes touched by an access of the given size at the given low offset.
  function automatic logic [3:0] lane_enables(acc_size_e sz, logic [1:0] lo);
    logic [3:0] be;
    case (sz)
      SZ_BYTE: be = 4'b0001 << lo;
      SZ_HALF: be = lo[1] ? 4'b1100 : 4'b0011;
      default: be = 4'b1111;
    endcase
    return be;
  endfunction

  // Moves right-justified write data onto the lanes it targets.
  function automatic logic [31:0] align_wdata(acc_size_e sz, logic [1:0] lo,
                                              logic [31:0] d);
    logic [31:0] r;
    case (sz)
      SZ_BYTE: r = {24'd0, d[7:0]} << (8 * lo);
      SZ_HALF: r = {16'd0, d[15:0]} << (lo[1] ? 16 : 0);
      default: r = d;
    endcase
    return r;
  endfunction

  // Replaces the enabled byte lanes of an old word.
  function automatic logic [31:0] merge_lanes(logic [31:0] old_w,
                                              logic [31:0] new_w,
                                              logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    return r;
  endfunction

  // Picks the addressed bytes out of an aligned word, zero-extended.
  function automatic logic [31:0] lane_extract(logic [31:0] w, acc_size_e sz,
                                               logic [1:0] lo);
    logic [31:0] s;
    s = w >> (8 * lo);
    case (sz)
      SZ_BYTE: return {24'd0, s[7:0]};
      SZ_HALF: return {16'd0, s[15:0]};
      default: return w;
    endcase
  endfunction

  // Value shown by a BAR holding all ones during the sizing handshake.
  function automatic logic [31:0] sizing_value(logic is_io, logic [31:0] size);
    logic [31:0] m;
    m = ~(size - 32'd1);
    if (is_io) return (m & 32'hFFFF_FFFC) | 32'h1;
    return m & 32'hFFFF_FFF0;
  endfunction

endpackage

// File: rtl/cfg_ident_regs.sv
module cfg_ident_regs
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h5A5A,
  parameter logic [23:0] CLASS_CODE = 24'h118000,
  parameter logic [7:0]  REV_ID     = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  word_off,
  input  logic [3:0]  be,
  input  logic [31:0] wdata_al,
  output logic        hit,
  output logic [31:0] word,
  output logic [15:0] cmd_q
);

  localparam logic [7:0] OFF_ID    = 8'h00;
  localparam logic [7:0] OFF_CMD   = 8'h04;
  localparam logic [7:0] OFF_CLASS = 8'h08;
  localparam logic [7:0] OFF_HDR   = 8'h0C;

  logic cmd_wr;
  assign cmd_wr = wr_en && (word_off == OFF_CMD) && (be[1:0] != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else if (cmd_wr)
      cmd_q <= merge_lanes({16'd0, cmd_q}, wdata_al, {2'b00, be[1:0]})[15:0];
  end

  always_comb begin
    hit  = 1'b1;
    word = '0;
    case (word_off)
      OFF_ID:    word = {DEVICE_ID, VENDOR_ID};
      OFF_CMD:   word = {16'd0, cmd_q};
      OFF_CLASS: word = {CLASS_CODE, REV_ID};
      OFF_HDR:   word = '0;
      default:   hit  = 1'b0;
    endcase
  end

  // R1: the command register moves only on a write aimed at it
  p_cmd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(cmd_q));

endmodule

// File: rtl/cfg_bar_bank.sv
module cfg_bar_bank
  import cfg_hdr_pkg::*;
#(
  parameter int NUM_BAR  = 6,
  parameter int NUM_IMPL = 2,
  parameter logic [NUM_BAR-1:0]    IS_IO    = 6'b000001,
  parameter logic [NUM_BAR*32-1:0] SIZE_TBL = {128'd0, 32'd256, 32'd1},
  localparam int IDX_W = $clog2(NUM_BAR)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        sel,
  input  logic [3:0]              be,
  input  logic [31:0]             wdata_al,
  output logic [31:0]             rd_word,
  output logic [NUM_BAR*32-1:0]   base_flat
);

  logic [NUM_BAR-1:0][31:0] bar_view;
  logic [NUM_BAR-1:0]       bar_wr;

  for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
    assign bar_wr[i] = wr_en && (sel == IDX_W'(i));
    if (i < NUM_IMPL) begin : g_impl
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (bar_wr[i])
          q <= merge_lanes(q, wdata_al, be) | {31'd0, IS_IO[i]};
      end
      assign bar_view[i] = (q == 32'hFFFF_FFFF)
                         ? sizing_value(IS_IO[i], SIZE_TBL[32*i +: 32]) : q;
      assign base_flat[32*i +: 32] = {q[31:1], 1'b0};
      if (IS_IO[i]) begin : g_io_chk
        // R4: an I/O BAR shows its space bit after any write
        p_space_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
          bar_wr[i] |=> q[0]);
      end
    end else begin : g_none
      assign bar_view[i]           = '0;
      assign base_flat[32*i +: 32] = '0;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NUM_BAR; k++)
      if (sel == IDX_W'(k)) rd_word = bar_view[k];
  end

endmodule

// File: rtl/cfg_cap_chain.sv
module cfg_cap_chain #(
  parameter logic [7:0] CAP_PTR_OFF = 8'h34,
  parameter logic [7:0] PM_OFF      = 8'h40,
  parameter logic [7:0] PCIE_OFF    = 8'h50,
  parameter logic [7:0] MSIX_OFF    = 8'h70,
  parameter logic [7:0] EA_OFF      = 8'h80,
  parameter logic [7:0] EA_ENTRIES  = 8'd4
) (
  input  logic [7:0]  word_off,
  input  logic        ea_en,
  output logic        hit,
  output logic [31:0] word
);

  localparam logic [7:0] ID_PM   = 8'h01;
  localparam logic [7:0] ID_PCIE = 8'h10;
  localparam logic [7:0] ID_MSIX = 8'h11;
  localparam logic [7:0] ID_EA   = 8'h14;

  logic [7:0] msix_next;
  assign msix_next = ea_en ? EA_OFF : 8'h00;

  always_comb begin
    hit  = 1'b1;
    word = '0;
    if (word_off == CAP_PTR_OFF)   word = {24'd0, PM_OFF};
    else if (word_off == PM_OFF)   word = {16'd0, PCIE_OFF, ID_PM};
    else if (word_off == PCIE_OFF) word = {16'd0, MSIX_OFF, ID_PCIE};
    else if (word_off == MSIX_OFF) word = {16'd0, msix_next, ID_MSIX};
    else if (word_off == EA_OFF && ea_en) word = {8'd0, EA_ENTRIES, 8'h00, ID_EA};
    else hit = 1'b0;
  end

endmodule

// File: rtl/cfg_hdr_responder.sv
module cfg_hdr_responder
  import cfg_hdr_pkg::*;
#(
  parameter int NUM_BAR  = 6,
  parameter int NUM_IMPL = 2,
  parameter logic [NUM_BAR-1:0]    BAR_IS_IO   = 6'b000001,
  parameter logic [NUM_BAR*32-1:0] BAR_SIZES   = {128'd0, 32'd256, 32'd1},
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h5A5A,
  parameter logic [23:0] CLASS_CODE = 24'h118000,
  parameter logic [7:0]  REV_ID     = 8'h01,
  parameter logic [7:0]  MSIX_OFF   = 8'h70,
  parameter logic [7:0]  EA_OFF     = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_req,
  input  logic                  cfg_we,
  input  logic [7:0]            cfg_off,
  input  logic [1:0]            cfg_size,
  input  logic [31:0]           cfg_wdata,
  input  logic                  ea_strap,
  output logic                  rd_valid,
  output logic [31:0]           rd_data,
  output logic [NUM_BAR*32-1:0] bar_base
);

  localparam int         IDX_W    = $clog2(NUM_BAR);
  localparam logic [7:0] BAR_FIRST = 8'h10;
  localparam logic [7:0] BAR_LAST  = 8'(BAR_FIRST + 4 * (NUM_BAR - 1));

  acc_size_e   sz;
  logic [1:0]  lo;
  logic [7:0]  word_off;
  logic [3:0]  be;
  logic [31:0] wdata_al;
  logic        is_rd, is_wr, in_bar;
  logic [IDX_W-1:0] bar_sel;
  logic [7:0]  bar_rel;

  assign sz       = acc_size_e'(cfg_size);
  assign lo       = cfg_off[1:0];
  assign word_off = {cfg_off[7:2], 2'b00};
  assign be       = lane_enables(sz, lo);
  assign wdata_al = align_wdata(sz, lo, cfg_wdata);
  assign is_rd    = cfg_req && !cfg_we;
  assign is_wr    = cfg_req && cfg_we;
  assign in_bar   = (word_off >= BAR_FIRST) && (word_off <= BAR_LAST);
  assign bar_rel  = word_off - BAR_FIRST;
  assign bar_sel  = IDX_W'(bar_rel[7:2]);

  logic        id_hit, cap_hit;
  logic [31:0] id_word, cap_word, bar_word;
  logic [15:0] cmd_q;

  cfg_ident_regs #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .CLASS_CODE(CLASS_CODE), .REV_ID(REV_ID)
  ) u_ident (
    .clk(clk), .rst_n(rst_n), .wr_en(is_wr), .word_off(word_off),
    .be(be), .wdata_al(wdata_al), .hit(id_hit), .word(id_word),
    .cmd_q(cmd_q)
  );

  cfg_bar_bank #(
    .NUM_BAR(NUM_BAR), .NUM_IMPL(NUM_IMPL),
    .IS_IO(BAR_IS_IO), .SIZE_TBL(BAR_SIZES)
  ) u_bars (
    .clk(clk), .rst_n(rst_n), .wr_en(is_wr && in_bar), .sel(bar_sel),
    .be(be), .wdata_al(wdata_al), .rd_word(bar_word), .base_flat(bar_base)
  );

  cfg_cap_chain #(.MSIX_OFF(MSIX_OFF), .EA_OFF(EA_OFF)) u_caps (
    .word_off(word_off), .ea_en(ea_strap), .hit(cap_hit), .word(cap_word)
  );

  logic [31:0] word_sel;
  always_comb begin
    if (id_hit)       word_sel = id_word;
    else if (in_bar)  word_sel = bar_word;
    else if (cap_hit) word_sel = cap_word;
    else              word_sel = '0;
  end

  // Registered read port plus a record of the request for the checks below.
  logic [7:0] rd_off_q;
  acc_size_e  rd_sz_q;
  logic       rd_strap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      rd_off_q   <= '0;
      rd_sz_q    <= SZ_BYTE;
      rd_strap_q <= 1'b0;
    end else begin
      rd_valid <= is_rd;
      if (is_rd) begin
        rd_data    <= lane_extract(word_sel, sz, lo);
        rd_off_q   <= cfg_off;
        rd_sz_q    <= sz;
        rd_strap_q <= ea_strap;
      end
    end
  end

  logic rd_unimpl_bar;
  assign rd_unimpl_bar = ({rd_off_q[7:2], 2'b00} >= 8'(BAR_FIRST + 4 * NUM_IMPL))
                      && ({rd_off_q[7:2], 2'b00} <= BAR_LAST);

  // R10: a read answers exactly one cycle later, a write never does
  p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> rd_valid);
  p_no_wr_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> !rd_valid);

  // R3: unimplemented BARs read zero
  p_unimpl_bar_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_unimpl_bar) |-> (rd_data == 32'd0));

  // R7: with the strap clear the MSI-X link terminates the chain
  p_ea_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_sz_q == SZ_WORD && rd_off_q == MSIX_OFF && !rd_strap_q)
      |-> (rd_data[15:8] == 8'h00));

  // R8: byte reads are zero-extended
  p_byte_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_sz_q == SZ_BYTE) |-> (rd_data[31:8] == 24'd0));

  // R1: the upper half of the command word is always zero
  p_cmd_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_sz_q == SZ_WORD && rd_off_q == 8'h04)
      |-> (rd_data[31:16] == 16'd0));

endmodule

// File: tb/cfg_hdr_responder_bench.sv
module cfg_hdr_responder_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_req = 1'b0;
  logic         cfg_we = 1'b0;
  logic [7:0]   cfg_off = '0;
  logic [1:0]   cfg_size = '0;
  logic [31:0]  cfg_wdata = '0;
  logic         ea_strap = 1'b0;
  logic         rd_valid;
  logic [31:0]  rd_data;
  logic [191:0] bar_base;

  always #5 clk = ~clk;

  cfg_hdr_responder u_cfg_hdr_responder (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_off(cfg_off), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
    .ea_strap(ea_strap), .rd_valid(rd_valid), .rd_data(rd_data),
    .bar_base(bar_base)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Monitor: every valid read pops one expectation.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R10 unexpected rd_valid", rd_data, 32'd0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(rd_data === it.exp, it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic cfg_write(logic [7:0] off, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = 1'b1; cfg_off = off; cfg_size = sz; cfg_wdata = d;
    @(negedge clk);
    cfg_req = 1'b0; cfg_we = 1'b0;
    check(rd_valid == 1'b0, "R10 write raised rd_valid", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic cfg_read(logic [7:0] off, logic [1:0] sz, logic [31:0] e, string tag);
    item_t it;
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = 1'b0; cfg_off = off; cfg_size = sz;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    cfg_req = 1'b0;
  endtask

  task automatic check_base(int idx, logic [31:0] e, string tag);
    @(negedge clk);
    check(bar_base[32*idx +: 32] === e, tag, bar_base[32*idx +: 32], e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    cfg_read(8'h04, 2'd2, 32'h0, "R11 command after reset");
    cfg_read(8'h10, 2'd2, 32'h0, "R11 BAR0 after reset");
    cfg_read(8'h14, 2'd2, 32'h0, "R11 BAR1 after reset");
    check_base(0, 32'h0, "R11 base0 after reset");
    check_base(1, 32'h0, "R11 base1 after reset");

    // R2: identity words and unlisted space
    cfg_read(8'h00, 2'd2, 32'h5A5A_C0DE, "R2 vendor/device word");
    cfg_read(8'h08, 2'd2, 32'h1180_0001, "R2 class/revision word");
    cfg_read(8'h0E, 2'd0, 32'h0, "R2 header type byte");
    cfg_read(8'h3C, 2'd2, 32'h0, "R2 unlisted offset 0x3C");
    cfg_read(8'hF0, 2'd2, 32'h0, "R2 unlisted offset 0xF0");

    // R1 / R9: command register
    cfg_write(8'h04, 2'd2, 32'h0000_0147);
    cfg_read(8'h04, 2'd2, 32'h0000_0147, "R1 command readback");
    cfg_write(8'h04, 2'd2, 32'hFFFF_0006);
    cfg_read(8'h04, 2'd2, 32'h0000_0006, "R1 upper half ignores writes");
    cfg_write(8'h05, 2'd0, 32'h0000_00AB);
    cfg_read(8'h04, 2'd2, 32'h0000_AB06, "R9 byte write to lane 1");
    cfg_read(8'h05, 2'd0, 32'h0000_00AB, "R8 byte read lane 1");

    // R4 / R12: BAR writes and exported bases
    cfg_write(8'h10, 2'd2, 32'h0000_2000);
    cfg_read(8'h10, 2'd2, 32'h0000_2001, "R4 BAR0 space bit forced");
    check_base(0, 32'h0000_2000, "R12 base0 after write");
    cfg_write(8'h14, 2'd2, 32'hE000_1001);
    cfg_read(8'h14, 2'd2, 32'hE000_1001, "R4 BAR1 bit0 as written");
    check_base(1, 32'hE000_1000, "R12 base1 after write");
    cfg_write(8'h16, 2'd0, 32'h0000_0055);
    cfg_read(8'h14, 2'd2, 32'hE055_1001, "R9 BAR1 byte lane 2 patch");
    cfg_write(8'h16, 2'd1, 32'h0000_1234);
    cfg_read(8'h14, 2'd2, 32'h1234_1001, "R9 BAR1 upper halfword patch");
    cfg_read(8'h16, 2'd1, 32'h0000_1234, "R8 halfword read upper");

    // R5: sizing handshake
    cfg_write(8'h10, 2'd2, 32'hFFFF_FFFF);
    cfg_write(8'h14, 2'd2, 32'hFFFF_FFFF);
    cfg_read(8'h10, 2'd2, 32'hFFFF_FFFD, "R5 BAR0 sizing mask");
    cfg_read(8'h14, 2'd2, 32'hFFFF_FF00, "R5 BAR1 sizing mask");
    cfg_read(8'h14, 2'd0, 32'h0000_0000, "R8 BAR1 sizing byte 0");
    cfg_read(8'h15, 2'd0, 32'h0000_00FF, "R8 BAR1 sizing byte 1");
    cfg_read(8'h12, 2'd1, 32'h0000_FFFF, "R8 BAR0 sizing upper half");
    cfg_write(8'h14, 2'd2, 32'h8000_0000);
    cfg_read(8'h14, 2'd2, 32'h8000_0000, "R5 BAR1 leaves sizing on new value");

    // R3: unimplemented BARs
    for (int b = 2; b < 6; b++) begin
      cfg_write(8'(8'h10 + 4 * b), 2'd2, 32'hDEAD_BEEF);
      cfg_read(8'(8'h10 + 4 * b), 2'd2, 32'h0, "R3 unimplemented BAR reads zero");
      check_base(b, 32'h0, "R3 unimplemented base slot");
    end
    cfg_write(8'h18, 2'd2, 32'hFFFF_FFFF);
    cfg_read(8'h18, 2'd2, 32'h0, "R3 unimplemented BAR no sizing");

    // R6 / R7: capability chain, strap clear
    cfg_read(8'h34, 2'd0, 32'h0000_0040, "R6 capability pointer");
    cfg_read(8'h40, 2'd2, 32'h0000_5001, "R6 PM header");
    cfg_read(8'h41, 2'd0, 32'h0000_0050, "R6 PM next byte");
    cfg_read(8'h50, 2'd2, 32'h0000_7010, "R6 PCIe header");
    cfg_read(8'h70, 2'd2, 32'h0000_0011, "R7 MSI-X end of chain, strap 0");
    cfg_read(8'h80, 2'd2, 32'h0, "R7 EA absent, strap 0");

    // R7: strap set
    @(negedge clk); ea_strap = 1'b1;
    cfg_read(8'h70, 2'd2, 32'h0000_8011, "R7 MSI-X links EA, strap 1");
    cfg_read(8'h71, 2'd0, 32'h0000_0080, "R7 MSI-X next byte, strap 1");
    cfg_read(8'h80, 2'd2, 32'h0004_0014, "R7 EA header");
    cfg_read(8'h82, 2'd0, 32'h0000_0004, "R7 EA entry count byte");

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R10 missing read responses", sb_q.size(), 32'd0);
    finish_run();
  end

endmodule